// File: doc/BRIEF.md
# Multi-Queue Receive Halt and Event Status Register

This block holds per-queue receive status for an Ethernet receive path with eight descriptor queues. Each queue owns two sticky flags. The stop flag is raised only by a hardware stop request for that queue. The event flag is raised when a frame-received event is reported for that ring. Software reads all flags through one 32-bit register and clears any of them by writing 1 to its bit.

The block also decides whether the frame now being received must be thrown away. When a frame starts, the block records the target queue index and looks at that queue's stop flag. If the queue becomes stopped while the frame is still arriving, the discard indication rises partway through the frame. It then stays high until the frame ends, even if software re-enables the queue in the meantime. A global graceful-stop input is accepted but never touches any flag or the discard indication.

The register read port is combinational and always valid. Frame start and frame end are single-cycle strobes with no back-pressure, because the receive path cannot be stalled by a status block.

Top module: `rx_queue_status`

## Requirements
- R1: After reset every flag is 0, the register reads 0x00000000 and `drop` is 0.
- R2: A 1 on `halt_req[q]` sets the stop flag of queue q at the next clock edge. Register bits use MSB-first numbering, so that flag is read at MSB-first position 8+q, which is LSB-first bit 23-q.
- R3: `gstop` never sets a stop flag and never changes `drop`.
- R4: A register write with 1 in a stop-flag position clears that flag. A 0 in that position leaves the flag unchanged.
- R5: A 1 on `rx_evt[r]` sets the event flag of ring r, read at MSB-first position 24+r, which is LSB-first bit 7-r.
- R6: An event flag is cleared by writing 1 to it. If a hardware set and a software clear reach the same stop or event flag in the same cycle, the flag ends up 1.
- R7: LSB-first bits 8 to 15 (reserved) and 24 to 31 always read 0, and writes to them have no effect.
- R8: In the cycle after `frm_start`, `drop` equals the stop flag that the queue selected by `frm_qidx` held in the start cycle.
- R9: If the current frame's queue becomes stopped during the frame, `drop` goes to 1 one cycle after the flag is set. It stays 1 until the frame ends, even if the flag is cleared first.
- R10: `drop` is 0 in the cycle after `frm_end` unless a new frame starts in that same cycle. A stop on any other queue does not affect `drop`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Write data; a 1 clears the matching flag |
| reg_rd_data | output | 32 | Current register contents |
| frm_start | input | 1 | First cycle of a received frame |
| frm_qidx | input | 3 | Target queue of the starting frame |
| frm_end | input | 1 | Last cycle of the current frame |
| halt_req | input | 8 | Per-queue hardware stop request |
| rx_evt | input | 8 | Per-ring frame-received event |
| gstop | input | 1 | Global graceful stop; no effect on this block |
| drop | output | 1 | Discard the current frame |

## Verification
The bench builds the block with its default of eight queues, so both end queues (0 and 7) and every register bit position are reachable. A vector table covers setting flags, clearing them, writes of 0 and same-cycle races between a hardware set and a software clear. Directed frame sequences then cover a stop flag that is already set when a frame starts, a stop that arrives mid-frame followed by an early clear, a stop on an unrelated queue, a frame end that coincides with a new frame start, and reset in the middle of activity.

// File: rtl/rqs_pkg.sv
package rqs_pkg;
  localparam int REG_W    = 32;
  localparam int HALT_POS = 8;   // MSB-first position of queue 0 stop flag
  localparam int EVT_POS  = 24;  // MSB-first position of ring 0 event flag

  // convert an MSB-first bit position into an LSB-first index
  function automatic int lsb_idx(input int msb_first_pos);
    return REG_W - 1 - msb_first_pos;
  endfunction
endpackage

// File: rtl/rqs_flag_bank.sv
module rqs_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  // sticky flags, write-1-to-clear, hardware set has priority
  always_ff @(posedge clk) begin
    if (!rst_n) flag_o <= '0;
    else        flag_o <= (flag_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/rqs_reg_map.sv
module rqs_reg_map
  import rqs_pkg::*;
#(
  parameter int NQ = 8
) (
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [NQ-1:0]    halt_i,
  input  logic [NQ-1:0]    evt_i,
  output logic [REG_W-1:0] rd_o,
  output logic [NQ-1:0]    halt_clr_o,
  output logic [NQ-1:0]    evt_clr_o
);
  logic unused_wr;
  assign unused_wr = ^wr_data;

  always_comb begin
    rd_o = '0;
    for (int q = 0; q < NQ; q++) begin
      rd_o[lsb_idx(HALT_POS + q)] = halt_i[q];
      rd_o[lsb_idx(EVT_POS + q)]  = evt_i[q];
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_clr
    assign halt_clr_o[q] = wr_en & wr_data[lsb_idx(HALT_POS + q)];
    assign evt_clr_o[q]  = wr_en & wr_data[lsb_idx(EVT_POS + q)];
  end
endmodule

// File: rtl/rqs_drop_ctl.sv
module rqs_drop_ctl #(
  parameter int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [QW-1:0] qidx_i,
  input  logic          end_i,
  input  logic [NQ-1:0] halt_i,
  output logic          drop_o
);
  logic          active_q;
  logic [QW-1:0] qidx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      qidx_q   <= '0;
      drop_o   <= 1'b0;
    end else if (start_i) begin
      // a new start wins over an end in the same cycle
      active_q <= 1'b1;
      qidx_q   <= qidx_i;
      drop_o   <= halt_i[qidx_i];
    end else if (end_i) begin
      active_q <= 1'b0;
      drop_o   <= 1'b0;
    end else if (active_q) begin
      drop_o   <= drop_o | halt_i[qidx_q];
    end
  end
endmodule

// File: rtl/rx_queue_status.sv
module rx_queue_status
  import rqs_pkg::*;
#(
  parameter int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  output logic [REG_W-1:0] reg_rd_data,
  input  logic             frm_start,
  input  logic [QW-1:0]    frm_qidx,
  input  logic             frm_end,
  input  logic [NQ-1:0]    halt_req,
  input  logic [NQ-1:0]    rx_evt,
  input  logic             gstop,
  output logic             drop
);
  logic [NQ-1:0] halt_flags, evt_flags, halt_clr, evt_clr;
  logic          unused_gstop;

  // the global stop is deliberately kept away from every flag
  assign unused_gstop = gstop;

  rqs_reg_map #(.NQ(NQ)) u_map (
    .wr_en      (reg_wr_en),
    .wr_data    (reg_wr_data),
    .halt_i     (halt_flags),
    .evt_i      (evt_flags),
    .rd_o       (reg_rd_data),
    .halt_clr_o (halt_clr),
    .evt_clr_o  (evt_clr)
  );

  rqs_flag_bank #(.W(NQ)) u_halt (
    .clk (clk), .rst_n (rst_n),
    .set_i (halt_req), .clr_i (halt_clr), .flag_o (halt_flags)
  );

  rqs_flag_bank #(.W(NQ)) u_evt (
    .clk (clk), .rst_n (rst_n),
    .set_i (rx_evt), .clr_i (evt_clr), .flag_o (evt_flags)
  );

  rqs_drop_ctl #(.NQ(NQ)) u_drop (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (frm_start),
    .qidx_i  (frm_qidx),
    .end_i   (frm_end),
    .halt_i  (halt_flags),
    .drop_o  (drop)
  );
endmodule

// File: rtl/rx_queue_status_chk.sv
module rx_queue_status_chk #(
  parameter int NQ = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr_en,
  input logic [31:0]   reg_wr_data,
  input logic [31:0]   reg_rd_data,
  input logic          frm_start,
  input logic          frm_end,
  input logic [NQ-1:0] halt_req,
  input logic [NQ-1:0] rx_evt,
  input logic          drop
);
  logic [NQ-1:0] halt_f, evt_f, halt_w;

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      halt_f[q] = reg_rd_data[23 - q];
      evt_f[q]  = reg_rd_data[7 - q];
      halt_w[q] = reg_wr_en & reg_wr_data[23 - q];
    end
  end

  AST_RST_VALUES: assert property (@(posedge clk) !rst_n |=> (reg_rd_data == 32'h0 && !drop)); // R1
  AST_HALT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(halt_req) & ~halt_f) == '0)); // R2
  AST_NO_SPUR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((halt_f & ~$past(halt_f) & ~$past(halt_req)) == '0)); // R3
  AST_HALT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((halt_f & $past(halt_w) & ~$past(halt_req)) == '0)); // R4
  AST_EVT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(rx_evt) & ~evt_f) == '0)); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |-> (reg_rd_data[15:8] == 8'h0 && reg_rd_data[31:24] == 8'h0)); // R7
  AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !frm_end && !frm_start) |=> drop); // R9
  AST_END_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_end && !frm_start) |=> !drop); // R10
endmodule

bind rx_queue_status rx_queue_status_chk #(.NQ(NQ)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_data (reg_wr_data),
  .reg_rd_data (reg_rd_data),
  .frm_start   (frm_start),
  .frm_end     (frm_end),
  .halt_req    (halt_req),
  .rx_evt      (rx_evt),
  .drop        (drop)
);

// File: tb/rx_queue_status_bench.sv
`timescale 1ns/1ps
module rx_queue_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        frm_start = 1'b0;
  logic [2:0]  frm_qidx = '0;
  logic        frm_end = 1'b0;
  logic [7:0]  halt_req = '0;
  logic [7:0]  rx_evt = '0;
  logic        gstop = 1'b0;
  logic        drop;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rx_queue_status u_rx_queue_status (
    .clk (clk), .rst_n (rst_n),
    .reg_wr_en (reg_wr_en), .reg_wr_data (reg_wr_data), .reg_rd_data (reg_rd_data),
    .frm_start (frm_start), .frm_qidx (frm_qidx), .frm_end (frm_end),
    .halt_req (halt_req), .rx_evt (rx_evt), .gstop (gstop), .drop (drop)
  );

  typedef struct packed {
    logic [7:0]  hreq;
    logic [7:0]  evt;
    logic        gs;
    logic        we;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  // stop flag q -> LSB bit 23-q, event flag r -> LSB bit 7-r
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{8'h01, 8'h00, 1'b0, 1'b0, 32'h0,         32'h0080_0000, 8'd2}, // R2 queue 0
    '{8'h00, 8'h00, 1'b1, 1'b0, 32'h0,         32'h0080_0000, 8'd3}, // R3 gstop alone
    '{8'h80, 8'h00, 1'b0, 1'b0, 32'h0,         32'h0081_0000, 8'd2}, // R2 queue 7
    '{8'h00, 8'h00, 1'b0, 1'b1, 32'h0001_0000, 32'h0080_0000, 8'd4}, // R4 clear queue 7
    '{8'h00, 8'h00, 1'b0, 1'b1, 32'h0000_0000, 32'h0080_0000, 8'd4}, // R4 write zeros
    '{8'h00, 8'h01, 1'b0, 1'b0, 32'h0,         32'h0080_0080, 8'd5}, // R5 ring 0
    '{8'h00, 8'hA0, 1'b1, 1'b0, 32'h0,         32'h0080_0085, 8'd5}, // R5 rings 5,7
    '{8'h00, 8'h00, 1'b0, 1'b1, 32'h0000_0080, 32'h0080_0005, 8'd6}, // R6 clear ring 0
    '{8'h00, 8'h00, 1'b0, 1'b1, 32'hFF00_FF00, 32'h0080_0005, 8'd7}, // R7 reserved
    '{8'h01, 8'h00, 1'b0, 1'b1, 32'h0080_0000, 32'h0080_0005, 8'd6}, // R6 stop race
    '{8'h00, 8'h20, 1'b0, 1'b1, 32'h0000_0004, 32'h0080_0005, 8'd6}, // R6 event race
    '{8'h00, 8'h00, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 8'd4}  // R4 clear all
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    tick();
    tick();
    check("R1 reset read", reg_rd_data, 32'h0);
    check("R1 reset drop", {31'h0, drop}, 32'h0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      halt_req = VEC[i].hreq; rx_evt = VEC[i].evt; gstop = VEC[i].gs;
      reg_wr_en = VEC[i].we; reg_wr_data = VEC[i].wd;
      tick();
      halt_req = '0; rx_evt = '0; gstop = 1'b0; reg_wr_en = 1'b0; reg_wr_data = '0;
      check($sformatf("R%0d vector %0d", VEC[i].req, i), reg_rd_data, VEC[i].exp);
    end

    // R8 frame to an enabled queue
    frm_start = 1'b1; frm_qidx = 3'd2; tick(); frm_start = 1'b0;
    check("R8 enabled queue", {31'h0, drop}, 32'h0);
    frm_end = 1'b1; tick(); frm_end = 1'b0;

    // R8 frame to a queue already stopped
    halt_req = 8'h08; tick(); halt_req = '0;
    frm_start = 1'b1; frm_qidx = 3'd3; tick(); frm_start = 1'b0;
    check("R8 stopped queue", {31'h0, drop}, 32'h1);
    tick();
    check("R9 hold", {31'h0, drop}, 32'h1);
    frm_end = 1'b1; tick(); frm_end = 1'b0;
    check("R10 end clears", {31'h0, drop}, 32'h0);
    reg_wr_en = 1'b1; reg_wr_data = 32'h0010_0000; tick(); reg_wr_en = 1'b0;
    check("R4 clear queue 3", reg_rd_data, 32'h0);

    // R9 stop arriving mid-frame, then cleared early
    frm_start = 1'b1; frm_qidx = 3'd4; tick(); frm_start = 1'b0;
    check("R9 before stop", {31'h0, drop}, 32'h0);
    halt_req = 8'h10; tick(); halt_req = '0;
    tick();
    check("R9 mid-frame stop", {31'h0, drop}, 32'h1);
    reg_wr_en = 1'b1; reg_wr_data = 32'h0008_0000; tick(); reg_wr_en = 1'b0;
    check("R4 clear queue 4", reg_rd_data, 32'h0);
    tick();
    check("R9 sticky after clear", {31'h0, drop}, 32'h1);
    frm_end = 1'b1; tick(); frm_end = 1'b0;
    check("R10 end after mid stop", {31'h0, drop}, 32'h0);

    // R10 other queue stopped, R3 gstop during frame
    frm_start = 1'b1; frm_qidx = 3'd1; tick(); frm_start = 1'b0;
    gstop = 1'b1; halt_req = 8'h40; tick(); halt_req = '0;
    tick(); tick(); gstop = 1'b0;
    check("R10 other queue", {31'h0, drop}, 32'h0);
    check("R3 only queue 6 stopped", reg_rd_data, 32'h0002_0000);
    frm_end = 1'b1; tick(); frm_end = 1'b0;

    // R10 end and start together
    frm_start = 1'b1; frm_qidx = 3'd6; tick(); frm_start = 1'b0;
    check("R8 queue 6", {31'h0, drop}, 32'h1);
    frm_end = 1'b1; frm_start = 1'b1; frm_qidx = 3'd1; tick(); frm_start = 1'b0;
    check("R10 back to back", {31'h0, drop}, 32'h0);
    tick(); frm_end = 1'b0;

    // R1 reset with state present
    rx_evt = 8'h02; tick(); rx_evt = '0;
    check("R5 ring 1", reg_rd_data, 32'h0002_0040);
    frm_start = 1'b1; frm_qidx = 3'd6; tick(); frm_start = 1'b0;
    rst_n = 1'b0; tick();
    check("R1 reset read", reg_rd_data, 32'h0);
    check("R1 reset drop", {31'h0, drop}, 32'h0);
    rst_n = 1'b1; tick();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule